// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock

This peripheral keeps wall time as a free-running 32-bit count of seconds. A programmable prescaler turns a slow reference clock into a once-per-second tick. The prescaler reload comes from a divider field, and a small trim field lets software remove a few input clocks from one tick period out of every 1024, correcting a reference that runs slightly fast or slow. Every tick advances the seconds counter. The incremented value is also compared against a software alarm value.

Software reaches the block over a simple single-cycle register bus. Reads are combinational and writes are taken on the clock edge that samples the write enable. The bus exposes the seconds count, the alarm value, the divider/trim word and a status word. The status word holds two sticky event flags and their interrupt enables. Each event drives its own interrupt line. A flag is cleared by writing a one to it. After reset the divider is zero, so the clock holds still until software programs it.

Top module: `sec_tick_rtc`

## Requirements
- R1: After reset every register reads 0 and both interrupt outputs are low.
- R2: With a non-zero divider D (divider/trim word bits 15:0), a tick occurs every D+1 clocks and each tick adds one to the seconds count. The first tick comes D+1 clocks after the edge that writes the divider/trim word, because that write restarts the prescaler and the 1024-tick trim sequence. While D is 0 the count does not advance.
- R3: With trim T (divider/trim word bits 23:16), every 1024th tick period is D+1-T clocks long, with a minimum of 1. All other periods stay D+1 clocks, and a T of 0 gives no correction.
- R4: Software can read and write the seconds count. On a tick it wraps from 0xFFFFFFFF to 0. If a software write and a tick fall in the same cycle, the written value is kept.
- R5: The tick flag (status bit 1) is set on the clock edge of every tick.
- R6: The alarm flag (status bit 0) is set on a tick edge when the incremented count equals the alarm register.
- R7: Writing 1 to status bit 0 or bit 1 clears that flag, and writing 0 leaves it unchanged. Status bits 3 (tick enable) and 2 (alarm enable) are plain read/write bits. Each enable sits two positions above its flag.
- R8: If a clearing write and a new event hit the same flag in the same cycle, the flag stays set.
- R9: The tick interrupt is high exactly while the tick flag and tick enable are both set. The alarm interrupt behaves the same way with the alarm flag and alarm enable.
- R10: With ALT_MAP=0 the register offsets are alarm 0x00, count 0x04, divider/trim 0x08 and status 0x10. With ALT_MAP=1 they are count 0x0, alarm 0x4, status 0x8 and divider/trim 0xC. Bits 31:24 of the divider/trim word and any unmapped offset read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Register byte offset |
| wrEn | input | 1 | Write strobe, sampled on the rising edge |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Combinational read data for addr |
| irqTick | output | 1 | Tick interrupt |
| irqAlarm | output | 1 | Alarm interrupt |

## Verification
A register write takes effect on the rising edge that samples it, and read data reflects the new value in the same cycle. The first tick lands exactly D+1 edges after the edge that writes the divider. Flags and interrupt lines change on that same tick edge, and the shortened 1024th period lands T clocks earlier. The bench drives the bus on falling edges and samples one nanosecond later. It counts falling edges from the write edge, so each expected count, flag and interrupt value is read in the first cycle it is due, and also in the cycle just before, where the old value must still hold.

// File: rtl/sec_rtc_pkg.sv
`timescale 1ns/1ps
package sec_rtc_pkg;
  // Write strobes issued by the register control to the time datapath
  typedef struct packed {
    logic wrCount;
    logic wrAlarm;
    logic wrTrim;
  } rtcStrobe_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_COUNT,
    SEL_ALARM,
    SEL_TRIM,
    SEL_STATUS
  } regSel_e;

  // Status word: flags in the low bits, each enable EN_OFFSET above its flag
  localparam int FLAG_ALARM = 0;
  localparam int FLAG_TICK  = 1;
  localparam int EN_OFFSET  = 2;
  localparam int NUM_EVT    = 2;
endpackage

// File: rtl/sec_rtc_dp.sv
`timescale 1ns/1ps
module sec_rtc_dp
  import sec_rtc_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 32,
  parameter int DIV_W     = 16,
  parameter int TRIM_W    = 8,
  parameter int TRIM_LOG2 = 10
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  rtcStrobe_t              strobe,
  input  logic [DATA_W-1:0]       wrData,
  output logic [CNT_W-1:0]        countQ,
  output logic [CNT_W-1:0]        alarmQ,
  output logic [DIV_W+TRIM_W-1:0] trimQ,
  output logic [DIV_W-1:0]        divider,
  output logic                    tickEvt,
  output logic                    alarmEvt
);
  localparam int TRIM_REG_W = DIV_W + TRIM_W;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [DIV_W-1:0]     presc;
  logic [TRIM_LOG2-1:0] trimCnt;
  logic [DIV_W-1:0]     trimVal;
  logic [DIV_W-1:0]     shortLimit;
  logic [DIV_W-1:0]     limit;
  logic                 running;
  logic                 lastPeriod;
  logic [CNT_W-1:0]     countNext;

  assign divider    = trimQ[DIV_W-1:0];
  assign trimVal    = {{(DIV_W-TRIM_W){1'b0}}, trimQ[TRIM_REG_W-1:DIV_W]};
  assign running    = (divider != '0);
  assign lastPeriod = &trimCnt;

  always_comb begin
    shortLimit = (divider > trimVal) ? (divider - trimVal) : '0;
    limit      = lastPeriod ? shortLimit : divider;
  end

  assign tickEvt   = running && (presc >= limit);
  assign countNext = countQ + CNT_ONE;
  assign alarmEvt  = tickEvt && (countNext == alarmQ);

  // Prescaler and trim sequence; a divider/trim write restarts both
  always_ff @(posedge clk) begin
    if (!rstN) begin
      trimQ   <= '0;
      presc   <= '0;
      trimCnt <= '0;
    end else if (strobe.wrTrim) begin
      trimQ   <= wrData[TRIM_REG_W-1:0];
      presc   <= '0;
      trimCnt <= '0;
    end else if (running) begin
      if (tickEvt) begin
        presc   <= '0;
        trimCnt <= trimCnt + TRIM_LOG2'(1);
      end else begin
        presc   <= presc + DIV_W'(1);
      end
    end
  end

  // Seconds counter: software write wins over a tick in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strobe.wrCount) begin
      countQ <= wrData[CNT_W-1:0];
    end else if (tickEvt) begin
      countQ <= countNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      alarmQ <= '0;
    end else if (strobe.wrAlarm) begin
      alarmQ <= wrData[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/sec_rtc_ctrl.sv
`timescale 1ns/1ps
module sec_rtc_ctrl
  import sec_rtc_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 5,
  parameter int CNT_W      = 32,
  parameter int TRIM_REG_W = 24,
  parameter bit ALT_MAP    = 1'b0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  wrEn,
  input  logic [DATA_W-1:0]     wrData,
  output logic [DATA_W-1:0]     rdData,
  output rtcStrobe_t            strobe,
  input  logic [CNT_W-1:0]      countQ,
  input  logic [CNT_W-1:0]      alarmQ,
  input  logic [TRIM_REG_W-1:0] trimQ,
  input  logic                  tickEvt,
  input  logic                  alarmEvt,
  output logic [NUM_EVT-1:0]    flagQ,
  output logic [NUM_EVT-1:0]    irqVec
);
  localparam logic [ADDR_W-1:0] OFF_COUNT  = ALT_MAP ? ADDR_W'('h0) : ADDR_W'('h4);
  localparam logic [ADDR_W-1:0] OFF_ALARM  = ALT_MAP ? ADDR_W'('h4) : ADDR_W'('h0);
  localparam logic [ADDR_W-1:0] OFF_TRIM   = ALT_MAP ? ADDR_W'('hC) : ADDR_W'('h8);
  localparam logic [ADDR_W-1:0] OFF_STATUS = ALT_MAP ? ADDR_W'('h8) : ADDR_W'('h10);
  localparam int STAT_W = NUM_EVT + EN_OFFSET;

  regSel_e            sel;
  logic               wrStatus;
  logic [NUM_EVT-1:0] enQ;
  logic [NUM_EVT-1:0] evtVec;

  always_comb begin
    sel = SEL_NONE;
    if (addr == OFF_COUNT)       sel = SEL_COUNT;
    else if (addr == OFF_ALARM)  sel = SEL_ALARM;
    else if (addr == OFF_TRIM)   sel = SEL_TRIM;
    else if (addr == OFF_STATUS) sel = SEL_STATUS;
  end

  always_comb begin
    strobe.wrCount = wrEn && (sel == SEL_COUNT);
    strobe.wrAlarm = wrEn && (sel == SEL_ALARM);
    strobe.wrTrim  = wrEn && (sel == SEL_TRIM);
    wrStatus       = wrEn && (sel == SEL_STATUS);
  end

  always_comb begin
    evtVec             = '0;
    evtVec[FLAG_ALARM] = alarmEvt;
    evtVec[FLAG_TICK]  = tickEvt;
  end

  // One flag/enable pair per event; the enable sits EN_OFFSET bits above
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    always_ff @(posedge clk) begin
      if (!rstN) begin
        flagQ[i] <= 1'b0;
        enQ[i]   <= 1'b0;
      end else begin
        flagQ[i] <= evtVec[i] | (flagQ[i] & ~(wrStatus & wrData[i]));
        if (wrStatus) enQ[i] <= wrData[i+EN_OFFSET];
      end
    end
    assign irqVec[i] = flagQ[i] & enQ[i];
  end

  always_comb begin
    unique case (sel)
      SEL_COUNT:  rdData = DATA_W'(countQ);
      SEL_ALARM:  rdData = DATA_W'(alarmQ);
      SEL_TRIM:   rdData = DATA_W'(trimQ);
      SEL_STATUS: rdData = DATA_W'({enQ, flagQ[EN_OFFSET-1:0]});
      default:    rdData = '0;
    endcase
  end

  logic unusedStatW;
  assign unusedStatW = (STAT_W == 0);
endmodule

// File: rtl/sec_tick_rtc.sv
`timescale 1ns/1ps
module sec_tick_rtc
  import sec_rtc_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 5,
  parameter int CNT_W     = 32,
  parameter int DIV_W     = 16,
  parameter int TRIM_W    = 8,
  parameter int TRIM_LOG2 = 10,
  parameter bit ALT_MAP   = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqTick,
  output logic              irqAlarm
);
  localparam int TRIM_REG_W = DIV_W + TRIM_W;

  rtcStrobe_t            strobe;
  logic [CNT_W-1:0]      countQ;
  logic [CNT_W-1:0]      alarmQ;
  logic [TRIM_REG_W-1:0] trimQ;
  logic [DIV_W-1:0]      divider;
  logic                  tickEvt;
  logic                  alarmEvt;
  logic [NUM_EVT-1:0]    flagQ;
  logic [NUM_EVT-1:0]    irqVec;

  sec_rtc_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .TRIM_REG_W(TRIM_REG_W), .ALT_MAP(ALT_MAP)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .strobe(strobe), .countQ(countQ), .alarmQ(alarmQ),
    .trimQ(trimQ), .tickEvt(tickEvt), .alarmEvt(alarmEvt),
    .flagQ(flagQ), .irqVec(irqVec)
  );

  sec_rtc_dp #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .DIV_W(DIV_W),
    .TRIM_W(TRIM_W), .TRIM_LOG2(TRIM_LOG2)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .countQ(countQ), .alarmQ(alarmQ), .trimQ(trimQ), .divider(divider),
    .tickEvt(tickEvt), .alarmEvt(alarmEvt)
  );

  assign irqTick  = irqVec[FLAG_TICK];
  assign irqAlarm = irqVec[FLAG_ALARM];
endmodule

// File: rtl/sec_rtc_chk.sv
`timescale 1ns/1ps
module sec_rtc_chk
  import sec_rtc_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DIV_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input rtcStrobe_t         strobe,
  input logic [CNT_W-1:0]   countQ,
  input logic [DIV_W-1:0]   divider,
  input logic               tickEvt,
  input logic               alarmEvt,
  input logic [NUM_EVT-1:0] flagQ
);
  // R5
  tick_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    tickEvt |=> flagQ[FLAG_TICK]);

  // R6
  alarm_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    alarmEvt |=> flagQ[FLAG_ALARM]);

  // R6
  alarm_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    alarmEvt |-> tickEvt);

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickEvt && !strobe.wrCount) |=> (countQ == $past(countQ) + CNT_W'(1)));

  // R2
  halt_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((divider == '0) && !strobe.wrCount) |=> $stable(countQ));
endmodule

bind sec_tick_rtc sec_rtc_chk #(.CNT_W(CNT_W), .DIV_W(DIV_W)) chk_i (
  .clk(clk), .rstN(rstN), .strobe(strobe), .countQ(countQ),
  .divider(divider), .tickEvt(tickEvt), .alarmEvt(alarmEvt), .flagQ(flagQ)
);

// File: tb/sec_tick_rtc_tb_top.sv
`timescale 1ns/1ps
module sec_tick_rtc_tb_top;
  localparam logic [4:0] A_ALARM = 5'h00, A_COUNT = 5'h04, A_TRIM = 5'h08,
                         A_STAT = 5'h10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqTick, irqAlarm;

  logic [4:0]  altAddr = '0;
  logic        altWrEn = 1'b0;
  logic [31:0] altWrData = '0;
  logic [31:0] altRdData;
  logic        altIrqTick, altIrqAlarm;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  sec_tick_rtc dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .irqTick(irqTick), .irqAlarm(irqAlarm)
  );

  sec_tick_rtc #(.ALT_MAP(1'b1)) dutAlt_i (
    .clk(clk), .rstN(rstN), .addr(altAddr), .wrEn(altWrEn), .wrData(altWrData),
    .rdData(altRdData), .irqTick(altIrqTick), .irqAlarm(altIrqAlarm)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitNeg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic altWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    altAddr = a; altWrData = d; altWrEn = 1'b1;
    @(negedge clk);
    altWrEn = 1'b0;
  endtask

  task automatic altRead(input logic [4:0] a, output logic [31:0] d);
    altAddr = a;
    #1;
    d = altRdData;
  endtask

  task automatic quiesce();
    busWrite(A_TRIM, 32'h0);
    busWrite(A_STAT, 32'h3);
  endtask

  task automatic testReset();
    busRead(A_ALARM, rv); check("R1 alarm reset", rv, 0);
    busRead(A_COUNT, rv); check("R1 count reset", rv, 0);
    busRead(A_TRIM, rv);  check("R1 trim reset", rv, 0);
    busRead(A_STAT, rv);  check("R1 status reset", rv, 0);
    check("R1 irqs reset", {30'b0, irqTick, irqAlarm}, 0);
    waitNeg(10);
    busRead(A_COUNT, rv); check("R2 halted with divider 0", rv, 0);
  endtask

  task automatic testTickPeriod();
    quiesce();
    busWrite(A_COUNT, 32'h0);
    busWrite(A_TRIM, 32'd3);
    waitNeg(3);
    busRead(A_COUNT, rv); check("R2 before first tick", rv, 0);
    waitNeg(1);
    busRead(A_COUNT, rv); check("R2 first tick", rv, 1);
    busRead(A_STAT, rv);  check("R5 tick flag", rv, 32'h2);
    check("R9 tick irq off while disabled", {31'b0, irqTick}, 0);
    waitNeg(3);
    busRead(A_COUNT, rv); check("R2 before second tick", rv, 1);
    waitNeg(1);
    busRead(A_COUNT, rv); check("R2 second tick", rv, 2);
  endtask

  task automatic testW1c();
    quiesce();
    busWrite(A_TRIM, 32'd1);
    waitNeg(2);
    busWrite(A_TRIM, 32'h0);
    busRead(A_STAT, rv); check("R5 flag set for w1c test", rv, 32'h2);
    busWrite(A_STAT, 32'h0);
    busRead(A_STAT, rv); check("R7 zero leaves flag", rv, 32'h2);
    busWrite(A_STAT, 32'hC);
    busRead(A_STAT, rv); check("R7 enables read back", rv, 32'hE);
    check("R9 tick irq on", {30'b0, irqTick, irqAlarm}, 32'h2);
    busWrite(A_STAT, 32'h6);
    busRead(A_STAT, rv); check("R7 one clears tick flag", rv, 32'h4);
    check("R9 tick irq off after clear", {31'b0, irqTick}, 0);
  endtask

  task automatic testAlarm();
    quiesce();
    busWrite(A_COUNT, 32'd10);
    busWrite(A_ALARM, 32'd12);
    busWrite(A_STAT, 32'hC);
    busWrite(A_TRIM, 32'd1);
    waitNeg(2);
    busRead(A_COUNT, rv); check("R2 count 11", rv, 11);
    busRead(A_STAT, rv);  check("R6 no alarm yet", rv, 32'hE);
    check("R9 irq tick only", {30'b0, irqTick, irqAlarm}, 32'h2);
    waitNeg(2);
    busRead(A_COUNT, rv); check("R6 count at alarm", rv, 12);
    busRead(A_STAT, rv);  check("R6 alarm flag", rv, 32'hF);
    check("R9 alarm irq", {30'b0, irqTick, irqAlarm}, 32'h3);
    busWrite(A_TRIM, 32'h0);
    busWrite(A_STAT, 32'hF);
    busRead(A_STAT, rv); check("R7 both flags cleared", rv, 32'hC);
    check("R9 irqs off", {30'b0, irqTick, irqAlarm}, 0);
  endtask

  task automatic testWrap();
    quiesce();
    busWrite(A_COUNT, 32'hFFFF_FFFE);
    busWrite(A_ALARM, 32'h0);
    busWrite(A_TRIM, 32'd1);
    waitNeg(2);
    busRead(A_COUNT, rv); check("R4 max count", rv, 32'hFFFF_FFFF);
    busRead(A_STAT, rv);  check("R6 no alarm at max", rv, 32'h2);
    waitNeg(2);
    busRead(A_COUNT, rv); check("R4 wrap to zero", rv, 0);
    busRead(A_STAT, rv);  check("R6 alarm after wrap", rv, 32'h3);
  endtask

  task automatic testWritePriority();
    quiesce();
    busWrite(A_COUNT, 32'd100);
    busWrite(A_TRIM, 32'd1);
    busWrite(A_COUNT, 32'd500);
    busRead(A_COUNT, rv); check("R4 write beats tick", rv, 500);
    waitNeg(2);
    busRead(A_COUNT, rv); check("R4 counting resumes", rv, 501);
  endtask

  task automatic testEventWins();
    quiesce();
    busWrite(A_TRIM, 32'd1);
    busWrite(A_STAT, 32'h2);
    busRead(A_STAT, rv); check("R8 event beats clear", rv, 32'h2);
    busWrite(A_TRIM, 32'h0);
    busWrite(A_STAT, 32'h2);
    busRead(A_STAT, rv); check("R7 clear when no event", rv, 0);
  endtask

  task automatic testTrim();
    quiesce();
    busWrite(A_COUNT, 32'h0);
    busWrite(A_TRIM, 32'h0003_0007);
    busRead(A_TRIM, rv); check("R10 trim word readback", rv, 32'h0003_0007);
    waitNeg(8188);
    busRead(A_COUNT, rv); check("R3 before short period end", rv, 1023);
    waitNeg(1);
    busRead(A_COUNT, rv); check("R3 1024th tick early", rv, 1024);
    waitNeg(7);
    busRead(A_COUNT, rv); check("R3 next period full length", rv, 1024);
    waitNeg(1);
    busRead(A_COUNT, rv); check("R3 1025th tick", rv, 1025);
    busWrite(A_TRIM, 32'h0);
  endtask

  task automatic testMaps();
    busWrite(A_TRIM, 32'hFF00_0000);
    busRead(A_TRIM, rv);  check("R10 upper trim bits read 0", rv, 0);
    busRead(5'h0C, rv);   check("R10 unmapped reads 0", rv, 0);
    altWrite(5'h0, 32'h55);
    altWrite(5'h4, 32'h66);
    altWrite(5'hC, 32'hFFAB_0000);
    altWrite(5'h8, 32'h4);
    altRead(5'h0, rv); check("R10 alt count", rv, 32'h55);
    altRead(5'h4, rv); check("R10 alt alarm", rv, 32'h66);
    altRead(5'hC, rv); check("R10 alt trim", rv, 32'h00AB_0000);
    altRead(5'h8, rv); check("R10 alt status", rv, 32'h4);
  endtask

  initial begin
    #(5.0 * 200000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    waitNeg(3);
    rstN = 1'b1;
    waitNeg(1);
    testReset();
    testTickPeriod();
    testW1c();
    testAlarm();
    testWrap();
    testWritePriority();
    testEventWins();
    testTrim();
    testMaps();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule